// File: doc/BRIEF.md
# I2C Reserved-Command Sequencer

This block is the control sequencer that sits above the bit-level engine of an I2C controller able to act as master or slave. Software or a bus master writes one 16-bit word: the upper byte is an operation command, the lower byte is the data the command works on. The block breaks each command into byte-level actions for the engine below it:
- issue a start condition
- send a byte and judge ACK or NAK
- receive a byte and return ACK or NAK
- issue a stop condition

The command itself says which ACK/NAK policy applies and whether a stop follows. When a command ends, the block either moves on to the next command by itself or stops and waits for software. Which one it does depends on the kind of frame just handled (address frame, continuous data, last data or stop) and on whether arbitration was lost. Sticky, write-one-to-clear flags tell software about:
- a judged NAK
- a data transfer needed in one of four directions (master receive, master transmit, slave receive, slave transmit)
- a write made while the block was busy

The bit-level engine is reached through a handshake. The block holds a request with an operation code until the engine returns a one-cycle done pulse. With that pulse the engine gives the NAK seen, the arbitration-lost status and the received byte.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the block is idle (`busy`=0, `eng_req`=0), `cur_cmd` is 0xA0, `is_master` is 0 and all seven flags are 0.
- R2: A write made while idle loads the low byte as data and the high byte as the command. A high byte whose upper nibble is neither 0xA nor 0xC loads 0xA0 instead. The loaded command starts at once.
- R3: Command bits:
  - upper nibble 0xA is the transmit family and 0xC the receive family
  - bit 0 issues a start before the byte
  - bit 1 issues a stop after the byte
  - bit 3 marks continuous data
  - bits 3 and 1 both set mean a stop on its own

  Engine operation codes are start=0, stop=1, transmit=2, receive=3. The transmitted byte is the data byte.
- R4: On a receive, `eng_send_nak` equals command bit 2 (0 returns ACK, 1 returns NAK). The received byte appears on `rx_data` once the byte completes.
- R5: A continuous command (bit 3=1, bit 1=0) leaves the command unchanged and goes idle after its byte. It then sets exactly one data request flag, chosen by direction and role:
  - flag bit 1 for master receive
  - flag bit 2 for master transmit
  - flag bit 3 for slave receive
  - flag bit 4 for slave transmit
- R6: An address frame is a transmit-family command with bit 0=1 and bits 1 and 3 both 0. When it completes, the block moves on to a new command by itself, based on bit 0 of the data byte sent:
  - if that bit is 1 (read), the command becomes 0xC8 and a receive starts at once
  - if that bit is 0 (write), the command becomes 0xAC, the block goes idle and flag bit 2 is set
- R7: A last-data command with no stop ends with the command 0xA0 and sets no flag. A command that issues a stop ends with the command 0xC8 and `is_master`=0, and sets no flag.
- R8: Arbitration loss on any operation skips the remaining operations. The block goes idle with the command 0xC8 and `is_master`=0, and sets no flag.
- R9: A transmit with bit 2=1 that receives NAK sets flag bit 5 (NAK) and flag bit 0 (command request). It skips any stop and leaves the command unchanged. A NAK on a transmit with bit 2=0 is ignored.
- R10: A write made while busy is ignored and sets flag bit 6 (overrun).
- R11: Flags are sticky and clear only where `irq_clr` has a 1.
- R12: `is_master` becomes 1 once a start completes without arbitration loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the command/data word |
| wr_word | input | 16 | Command in [15:8], data in [7:0] |
| irq_clr | input | 7 | Write-one-to-clear mask for the flags |
| eng_done | input | 1 | Engine finished the current operation (one cycle) |
| eng_nak | input | 1 | NAK seen on the byte that finished |
| eng_arb_lost | input | 1 | Arbitration lost on the operation that finished |
| eng_rx_byte | input | 8 | Byte received by the engine |
| eng_req | output | 1 | Operation request to the engine |
| eng_op | output | 2 | Operation code: start 0, stop 1, transmit 2, receive 3 |
| eng_tx_byte | output | 8 | Byte to transmit |
| eng_send_nak | output | 1 | Return NAK (1) or ACK (0) on a receive |
| busy | output | 1 | A command is executing |
| is_master | output | 1 | The block currently owns the bus as master |
| cur_cmd | output | 8 | Command now held |
| rx_data | output | 8 | Last received byte |
| irq_flags | output | 7 | Flags: 0 command request, 1 master rx, 2 master tx, 3 slave rx, 4 slave tx, 5 NAK, 6 overrun |

## Verification
The hardest cases to reach are the ones where an abnormal engine reply cuts short a command with several operations. Two examples are an arbitration loss on the transmit that follows a start, and a judged NAK on a byte that should have been followed by a stop. In both cases the skipped operations must never be requested. To reach them, the stub engine in the bench can be set to report arbitration loss on one chosen operation code, and to return NAK on every byte. The bench logs each operation the stub served, so it can compare the exact order of operations, not just the final state.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W  = 8;
  localparam int CMD_W   = 8;
  localparam int WORD_W  = CMD_W + BYTE_W;
  localparam int NUM_IRQ = 7;
  localparam int NUM_DREQ = 4;

  localparam int IRQ_CREQ  = 0;
  localparam int IRQ_MRREQ = 1;
  localparam int IRQ_MTREQ = 2;
  localparam int IRQ_SRREQ = 3;
  localparam int IRQ_STREQ = 4;
  localparam int IRQ_NAK   = 5;
  localparam int IRQ_OVR   = 6;

  localparam logic [CMD_W-1:0] CMD_DEFAULT  = 8'hA0;
  localparam logic [CMD_W-1:0] CMD_SLV_IDLE = 8'hC8;
  localparam logic [CMD_W-1:0] CMD_MTX_CONT = 8'hAC;
  localparam logic [CMD_W-1:0] CMD_MRX_CONT = 8'hC8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_TX    = 2'd2,
    OP_RX    = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    PH_IDLE, PH_START, PH_BYTE, PH_STOP
  } phase_e;

  typedef struct packed {
    logic fam_rx;
    logic pre_start;
    logic post_stop;
    logic policy;
    logic cont;
    logic stop_only;
    logic addr_frame;
  } cmd_info_t;

  function automatic logic [CMD_W-1:0] sanitize_cmd(input logic [CMD_W-1:0] c);
    if (c[7:4] == 4'hA || c[7:4] == 4'hC) return c;
    return CMD_DEFAULT;
  endfunction

  function automatic cmd_info_t decode_cmd(input logic [CMD_W-1:0] c);
    cmd_info_t i;
    i.fam_rx     = (c[7:4] == 4'hC);
    i.pre_start  = c[0];
    i.policy     = c[2];
    i.stop_only  = c[3] & c[1];
    i.cont       = c[3] & ~c[1];
    i.post_stop  = c[1] & ~c[3];
    i.addr_frame = ~i.fam_rx & c[0] & ~c[1] & ~c[3];
    return i;
  endfunction

  function automatic phase_e first_phase(input cmd_info_t i);
    if (i.stop_only) return PH_STOP;
    if (i.pre_start) return PH_START;
    return PH_BYTE;
  endfunction

  // one-hot over {slave tx, slave rx, master tx, master rx}
  function automatic logic [NUM_DREQ-1:0] dreq_sel(input logic fam_rx, input logic master);
    logic [NUM_DREQ-1:0] v;
    v = '0;
    v[{~master, ~fam_rx}] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import i2c_seq_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output cmd_info_t        info
);
  always_comb info = decode_cmd(cmd);
endmodule

// File: rtl/seq_irq_bank.sv
module seq_irq_bank #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic nxt;
    always_comb nxt = set[i] | (flag_q[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= nxt;
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import i2c_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_word,
  input  cmd_info_t           info,
  input  logic                eng_done,
  input  logic                eng_nak,
  input  logic                eng_arb_lost,
  input  logic [BYTE_W-1:0]   eng_rx_byte,
  output phase_e              phase,
  output logic [CMD_W-1:0]    cmd_q,
  output logic [BYTE_W-1:0]   data_q,
  output logic [BYTE_W-1:0]   rx_q,
  output logic                master_q,
  output logic                ev_ovr,
  output logic                ev_nak,
  output logic                ev_arb,
  output logic [NUM_DREQ-1:0] ev_dreq
);
  phase_e              ph_q, ph_d;
  logic [CMD_W-1:0]    cmd_d, new_cmd;
  logic [BYTE_W-1:0]   data_d, rx_d;
  logic                mst_d, accept, step_done;

  always_comb begin
    new_cmd   = sanitize_cmd(wr_word[WORD_W-1:BYTE_W]);
    accept    = wr_en && (ph_q == PH_IDLE);
    ev_ovr    = wr_en && (ph_q != PH_IDLE);
    step_done = eng_done && (ph_q != PH_IDLE);
    ph_d   = ph_q;
    cmd_d  = cmd_q;
    data_d = data_q;
    rx_d   = rx_q;
    mst_d  = master_q;
    ev_nak = 1'b0;
    ev_arb = 1'b0;
    ev_dreq = '0;
    if (accept) begin
      cmd_d  = new_cmd;
      data_d = wr_word[BYTE_W-1:0];
      ph_d   = first_phase(decode_cmd(new_cmd));
    end else if (step_done && eng_arb_lost) begin
      ev_arb = 1'b1;
      cmd_d  = CMD_SLV_IDLE;
      mst_d  = 1'b0;
      ph_d   = PH_IDLE;
    end else if (step_done) begin
      unique case (ph_q)
        PH_START: begin
          mst_d = 1'b1;
          ph_d  = PH_BYTE;
        end
        PH_BYTE: begin
          if (info.fam_rx) rx_d = eng_rx_byte;
          if (!info.fam_rx && info.policy && eng_nak) begin
            ev_nak = 1'b1;
            ph_d   = PH_IDLE;
          end else if (info.post_stop) begin
            ph_d = PH_STOP;
          end else if (info.cont) begin
            ev_dreq = dreq_sel(info.fam_rx, master_q);
            ph_d    = PH_IDLE;
          end else if (info.addr_frame) begin
            if (data_q[0]) begin
              cmd_d = CMD_MRX_CONT;
              ph_d  = PH_BYTE;
            end else begin
              cmd_d   = CMD_MTX_CONT;
              ev_dreq = dreq_sel(1'b0, master_q);
              ph_d    = PH_IDLE;
            end
          end else begin
            cmd_d = CMD_DEFAULT;
            ph_d  = PH_IDLE;
          end
        end
        PH_STOP: begin
          cmd_d = CMD_SLV_IDLE;
          mst_d = 1'b0;
          ph_d  = PH_IDLE;
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cmd_q    <= CMD_DEFAULT;
      data_q   <= '0;
      rx_q     <= '0;
      master_q <= 1'b0;
    end else begin
      ph_q     <= ph_d;
      cmd_q    <= cmd_d;
      data_q   <= data_d;
      rx_q     <= rx_d;
      master_q <= mst_d;
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WORD_W-1:0]   wr_word,
  input  logic [NUM_IRQ-1:0]  irq_clr,
  input  logic                eng_done,
  input  logic                eng_nak,
  input  logic                eng_arb_lost,
  input  logic [BYTE_W-1:0]   eng_rx_byte,
  output logic                eng_req,
  output logic [1:0]          eng_op,
  output logic [BYTE_W-1:0]   eng_tx_byte,
  output logic                eng_send_nak,
  output logic                busy,
  output logic                is_master,
  output logic [CMD_W-1:0]    cur_cmd,
  output logic [BYTE_W-1:0]   rx_data,
  output logic [NUM_IRQ-1:0]  irq_flags
);
  phase_e              phase;
  cmd_info_t           info;
  logic [CMD_W-1:0]    cmd_q;
  logic [BYTE_W-1:0]   data_q, rx_q;
  logic                master_q;
  // named internal events, observed by the checker
  logic                ev_ovr, ev_nak, ev_arb;
  logic [NUM_DREQ-1:0] ev_dreq;
  logic [NUM_IRQ-1:0]  irq_set;

  seq_decode u_dec (.cmd(cmd_q), .info(info));

  seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .info(info),
    .eng_done(eng_done), .eng_nak(eng_nak), .eng_arb_lost(eng_arb_lost),
    .eng_rx_byte(eng_rx_byte), .phase(phase), .cmd_q(cmd_q), .data_q(data_q),
    .rx_q(rx_q), .master_q(master_q), .ev_ovr(ev_ovr), .ev_nak(ev_nak),
    .ev_arb(ev_arb), .ev_dreq(ev_dreq)
  );

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_CREQ]  = ev_nak;
    irq_set[IRQ_NAK]   = ev_nak;
    irq_set[IRQ_OVR]   = ev_ovr;
    irq_set[IRQ_MRREQ] = ev_dreq[0];
    irq_set[IRQ_MTREQ] = ev_dreq[1];
    irq_set[IRQ_SRREQ] = ev_dreq[2];
    irq_set[IRQ_STREQ] = ev_dreq[3];
  end

  seq_irq_bank #(.N(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set), .clr(irq_clr), .flags(irq_flags)
  );

  always_comb begin
    unique case (phase)
      PH_START: eng_op = OP_START;
      PH_STOP:  eng_op = OP_STOP;
      PH_BYTE:  eng_op = info.fam_rx ? OP_RX : OP_TX;
      default:  eng_op = OP_START;
    endcase
  end

  assign eng_req      = (phase != PH_IDLE);
  assign busy         = (phase != PH_IDLE);
  assign eng_tx_byte  = data_q;
  assign eng_send_nak = info.policy;
  assign is_master    = master_q;
  assign cur_cmd      = cmd_q;
  assign rx_data      = rx_q;
endmodule

// File: rtl/seq_chk.sv
module seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [6:0] irq_clr,
  input logic       eng_done,
  input logic       eng_arb_lost,
  input logic       eng_req,
  input logic [1:0] eng_op,
  input logic [7:0] eng_tx_byte,
  input logic       busy,
  input logic       is_master,
  input logic [7:0] cur_cmd,
  input logic [6:0] irq_flags,
  input logic       ev_nak,
  input logic [3:0] ev_dreq
);
  // R2
  valid_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_cmd[7:4] == 4'hA) || (cur_cmd[7:4] == 4'hC));

  // R10
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy |=> irq_flags[6]);

  // R10
  ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && busy && !eng_done |=> $stable(cur_cmd));

  // R8
  arb_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && eng_done && eng_arb_lost |=> !busy && !is_master && cur_cmd == 8'hC8);

  // R9
  nak_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nak |=> irq_flags[5] && irq_flags[0] && !busy);

  // R5
  one_dreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_dreq));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op) && $stable(eng_tx_byte));

  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_flags & $past(irq_flags & ~irq_clr)) == $past(irq_flags & ~irq_clr)));
endmodule

bind i2c_cmd_seq seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .irq_clr(irq_clr), .eng_done(eng_done),
  .eng_arb_lost(eng_arb_lost), .eng_req(eng_req), .eng_op(eng_op),
  .eng_tx_byte(eng_tx_byte), .busy(busy), .is_master(is_master), .cur_cmd(cur_cmd),
  .irq_flags(irq_flags), .ev_nak(ev_nak), .ev_dreq(ev_dreq)
);

// File: tb/i2c_cmd_seq_test.sv
`timescale 1ns/1ps
module i2c_cmd_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_word = '0;
  logic [6:0]  irq_clr = '0;
  logic        eng_done = 1'b0, eng_nak = 1'b0, eng_arb_lost = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        eng_req, eng_send_nak, busy, is_master;
  logic [1:0]  eng_op;
  logic [7:0]  eng_tx_byte, cur_cmd, rx_data;
  logic [6:0]  irq_flags;

  int checks = 0, fails = 0;
  logic finished = 1'b0;

  // stub engine controls and log
  logic       stub_nak = 1'b0;
  logic [2:0] arb_sel = 3'd4;
  logic [7:0] stub_rx = 8'h00;
  int         cnt = 0;
  int         log_n = 0;
  logic [1:0] log_op [16];
  logic [7:0] log_tx [16];
  logic       log_snak [16];

  always #4 clk = ~clk;

  i2c_cmd_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .irq_clr(irq_clr),
    .eng_done(eng_done), .eng_nak(eng_nak), .eng_arb_lost(eng_arb_lost),
    .eng_rx_byte(eng_rx_byte), .eng_req(eng_req), .eng_op(eng_op),
    .eng_tx_byte(eng_tx_byte), .eng_send_nak(eng_send_nak), .busy(busy),
    .is_master(is_master), .cur_cmd(cur_cmd), .rx_data(rx_data), .irq_flags(irq_flags)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      eng_done = 1'b0; cnt = 0;
    end else if (eng_done) begin
      eng_done = 1'b0; eng_arb_lost = 1'b0;
    end else if (eng_req) begin
      cnt++;
      if (cnt == 3) begin
        cnt = 0;
        eng_done = 1'b1;
        eng_nak = stub_nak;
        eng_rx_byte = stub_rx;
        eng_arb_lost = (arb_sel == {1'b0, eng_op});
        if (log_n < 16) begin
          log_op[log_n] = eng_op; log_tx[log_n] = eng_tx_byte; log_snak[log_n] = eng_send_nak;
        end
        log_n++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 1000 && busy; n++) @(negedge clk);
  endtask

  task automatic issue(input logic [15:0] w);
    log_n = 0;
    @(negedge clk); wr_en = 1'b1; wr_word = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run(input logic [15:0] w);
    issue(w);
    wait_idle();
  endtask

  task automatic clear(input logic [6:0] m);
    @(negedge clk); irq_clr = m;
    @(negedge clk); irq_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 eng_req", eng_req, 0);
    chk("R1 cmd", cur_cmd, 8'hA0);
    chk("R1 master", is_master, 0);
    chk("R1 flags", irq_flags, 0);
  endtask

  task automatic t_sanitize();
    issue(16'h550F);
    chk("R2 invalid->A0", cur_cmd, 8'hA0);
    chk("R2 busy", busy, 1);
    wait_idle();
    chk("R2 ops", {log_n, log_op[0], log_tx[0]}, {32'd1, 2'd2, 8'h0F} >> 0);
    issue(16'hB300);
    chk("R2 invalid B3->A0", cur_cmd, 8'hA0);
    wait_idle();
    issue(16'hC000);
    chk("R2 valid C0 kept", cur_cmd, 8'hC0);
    wait_idle();
    chk("R7 last rx no stop -> A0", cur_cmd, 8'hA0);
    chk("R2 flags", irq_flags, 0);
  endtask

  task automatic t_addr_write();
    run(16'hA150);
    chk("R3 ops start,tx", {log_n, log_op[0], log_op[1], log_tx[1]}, {32'd2, 2'd0, 2'd2, 8'h50});
    chk("R6 write -> AC", cur_cmd, 8'hAC);
    chk("R6 MTREQ", irq_flags, 7'h04);
    chk("R12 master", is_master, 1);
    clear(7'h7F);
  endtask

  task automatic t_cont_tx();
    run(16'hAC33);
    chk("R5 ops tx", {log_n, log_op[0], log_tx[0]}, {32'd1, 2'd2, 8'h33});
    chk("R5 cmd kept", cur_cmd, 8'hAC);
    chk("R5 master tx req", irq_flags, 7'h04);
    clear(7'h7F);
    run(16'hA011);
    chk("R7 last -> A0", cur_cmd, 8'hA0);
    chk("R7 no flag", irq_flags, 0);
    chk("R7 still master", is_master, 1);
  endtask

  task automatic t_last_stop();
    run(16'hA244);
    chk("R3 ops tx,stop", {log_n, log_op[0], log_op[1]}, {32'd2, 2'd2, 2'd1});
    chk("R7 stop -> C8", cur_cmd, 8'hC8);
    chk("R7 master off", is_master, 0);
    chk("R7 no flag", irq_flags, 0);
  endtask

  task automatic t_addr_read();
    stub_rx = 8'h5A;
    run(16'hA1A1);
    chk("R6 ops start,tx,rx", {log_n, log_op[0], log_op[1], log_op[2]}, {32'd3, 2'd0, 2'd2, 2'd3});
    chk("R4 ack on auto rx", log_snak[2], 0);
    chk("R4 rx data", rx_data, 8'h5A);
    chk("R6 read -> C8", cur_cmd, 8'hC8);
    chk("R5 master rx req", irq_flags, 7'h02);
    clear(7'h7F);
    stub_rx = 8'h3C;
    run(16'hC600);
    chk("R4 ops rx,stop", {log_n, log_op[0], log_op[1]}, {32'd2, 2'd3, 2'd1});
    chk("R4 nak returned", log_snak[0], 1);
    chk("R4 rx data 2", rx_data, 8'h3C);
    chk("R7 master off", is_master, 0);
    chk("R7 no flag", irq_flags, 0);
  endtask

  task automatic t_nak();
    stub_nak = 1'b1;
    run(16'hA552);
    chk("R9 ops", {log_n, log_op[0], log_op[1]}, {32'd2, 2'd0, 2'd2});
    chk("R9 flags nak+creq", irq_flags, 7'h21);
    chk("R9 cmd kept", cur_cmd, 8'hA5);
    clear(7'h7F);
    run(16'hA677);
    chk("R9 stop skipped", log_n, 1);
    chk("R9 flags 2", irq_flags, 7'h21);
    chk("R9 master kept", is_master, 1);
    clear(7'h7F);
    run(16'hA012);
    chk("R9 unjudged ignored cmd", cur_cmd, 8'hA0);
    chk("R9 unjudged no flag", irq_flags, 0);
    stub_nak = 1'b0;
    run(16'hAA00);
    chk("R3 stop only", {log_n, log_op[0]}, {32'd1, 2'd1});
    chk("R7 stop only -> C8", cur_cmd, 8'hC8);
  endtask

  task automatic t_arb();
    arb_sel = 3'd0;
    run(16'hA360);
    chk("R8 ops start only", {log_n, log_op[0]}, {32'd1, 2'd0});
    chk("R8 cmd", cur_cmd, 8'hC8);
    chk("R8 master", is_master, 0);
    chk("R8 flags", irq_flags, 0);
    arb_sel = 3'd2;
    run(16'hA162);
    chk("R8 ops start,tx", {log_n, log_op[1]}, {32'd2, 2'd2});
    chk("R8 cmd after tx loss", cur_cmd, 8'hC8);
    chk("R8 master lost", is_master, 0);
    chk("R8 flags 2", irq_flags, 0);
    arb_sel = 3'd4;
  endtask

  task automatic t_slave();
    run(16'hC800);
    chk("R5 slave rx req", irq_flags, 7'h08);
    clear(7'h7F);
    run(16'hAC00);
    chk("R5 slave tx req", irq_flags, 7'h10);
  endtask

  task automatic t_overrun();
    log_n = 0;
    @(negedge clk); wr_en = 1'b1; wr_word = 16'hA000;
    @(negedge clk); wr_word = 16'hC100;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 cmd kept", cur_cmd, 8'hA0);
    wait_idle();
    chk("R10 single op", {log_n, log_op[0]}, {32'd1, 2'd2});
    chk("R10 ovr flag", irq_flags, 7'h50);
    clear(7'h40);
    chk("R11 partial clear", irq_flags, 7'h10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R1-related timeout actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sanitize();
    t_addr_write();
    t_cont_tx();
    t_last_stop();
    t_addr_read();
    t_nak();
    t_arb();
    t_slave();
    t_overrun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule